// File: doc/BRIEF.md
# Fixed-Latency Read Capture FIFO

This block collects read bursts returning from a DDR-style memory and hands them to the controller clock domain. Returning words are written into a small dual-clock FIFO on the data strobe, which is modelled here as a second clock with a write enable. The output side of the FIFO cannot tell when a burst has arrived, so readout does not wait on a FIFO flag. Each read-issue pulse starts its own countdown. When that countdown expires, the FIFO is drained for one eight-beat burst, one word per controller cycle.

The countdown length is the programmed CAS latency plus a software-set number of extra align cycles. Two more cycles are added when the low-power DDR mode bit is set, to absorb strobe-to-clock skew. Software must choose the align count large enough to cover the FIFO stage and the board round trip. If a beat is due while the FIFO is empty, the block outputs all-ones for that beat and sets a sticky error flag. Write and read pointers cross between the two clock domains as Gray codes through two-flop synchronizers.

Top module: `rd_capture_fifo`

## Requirements
- R1: After reset, `rd_valid` and `rd_err` are low, no read is pending and the FIFO is empty.
- R2: Words written on rising `dqs_clk` edges while `dqs_we` is high leave on `rd_data` in the same order, one word per valid beat.
- R3: With `cfg_lp` low, a read issued at controller edge k has its first valid beat in the cycle after edge k+D, where D = `cfg_cl` + `cfg_ralat`. A CAS latency of 6 is a supported setting.
- R4: With `cfg_lp` high, the same delay becomes D = `cfg_cl` + `cfg_ralat` + 2.
- R5: Every read produces exactly 8 consecutive cycles of `rd_valid`, and the FIFO is popped at most once per cycle.
- R6: Reads issued 8 or more cycles apart each get their own timer and their own 8-beat window. Up to `NUM_TIMERS` reads may be pending at once.
- R7: A beat that is due while the FIFO is empty is output as all-ones (16'hFFFF at the default width) with `rd_valid` high, consumes no FIFO entry, and sets `rd_err`.
- R8: `rd_err` stays high until reset, and reset clears it.
- R9: The configuration inputs change only while no read is pending or being output.
- R10: Pointers cross the clock domains as Gray codes that change by at most one bit per edge, and the FIFO is never written while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rd_issue | input | 1 | One-cycle pulse marking a read command |
| cfg_cl | input | CFGW | CAS latency in controller cycles |
| cfg_ralat | input | CFGW | Extra read-align cycles |
| cfg_lp | input | 1 | Low-power DDR mode, adds two cycles |
| dqs_clk | input | 1 | Returning data strobe, used as the write clock |
| dqs_we | input | 1 | Strobe-domain write enable |
| dqs_data | input | DW | Strobe-domain data word |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DW | Read beat data, all-ones on underrun |
| rd_err | output | 1 | Sticky underrun flag |

## Verification
A read sampled at controller edge k must keep `rd_valid` low up to edge k+D-1 and must show beat b after edge k+D+b. `rd_valid` must fall after edge k+D+8. The bench computes D from the programmed fields and samples `rd_valid` and `rd_data` on falling controller edges at exactly those cycles. It sweeps CAS latency 4 to 6, align counts 1 to 3 and both modes. Strobe writes begin right after the issue, so the two synchronizer stages finish well inside the shortest delay. The underrun, partial-burst, back-to-back and reset cases are each checked at their own due cycles.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int BURST_LEN = 8;
  localparam int BEAT_W    = $clog2(BURST_LEN);
  localparam int LP_EXTRA  = 2;
endpackage

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;

  assert_gray_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sync_q ^ $past(sync_q)) <= 1);
endmodule

// File: rtl/capture_fifo.sv
module capture_fifo #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic          empty,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rsync;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wsync;
  logic          wfull;

  // write side, strobe domain
  always_comb begin
    wbin_d  = wbin_q;
    if (we) wbin_d = wbin_q + 1'b1;
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (we) mem[wbin_q[AW-1:0]] <= wdata;
  end

  gray_sync #(.W(PW)) u_rsync (.clk(wclk), .rst_n(rst_n), .din(rgray_q), .dout(rsync));
  assign wfull = (wgray_q == {~rsync[PW-1:PW-2], rsync[PW-3:0]});

  // read side, controller domain
  always_comb begin
    rbin_d  = rbin_q;
    if (pop) rbin_d = rbin_q + 1'b1;
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  gray_sync #(.W(PW)) u_wsync (.clk(rclk), .rst_n(rst_n), .din(wgray_q), .dout(wsync));
  assign empty = (rgray_q == wsync);
  assign rdata = mem[rbin_q[AW-1:0]];

  assert_no_overflow_R10: assert property (@(posedge wclk) disable iff (!rst_n)
    we |-> !wfull);
  assert_pop_nonempty_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/lat_timers.sv
module lat_timers #(
  parameter int NT = 4,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          fire,
  output logic          busy
);
  logic [TW-1:0] t_q [NT];
  logic [TW-1:0] t_d [NT];
  logic [NT-1:0] grant, free_vec, fire_vec;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NT; i++) begin
      if (!found && free_vec[i]) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_slot
    assign free_vec[g] = (t_q[g] == '0);
    assign fire_vec[g] = (t_q[g] == TW'(1));

    always_comb begin
      t_d[g] = t_q[g];
      if (load && grant[g])    t_d[g] = load_val;
      else if (!free_vec[g])   t_d[g] = t_q[g] - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) t_q[g] <= '0;
      else        t_q[g] <= t_d[g];
    end
  end

  assign fire = |fire_vec;
  assign busy = ~&free_vec;

  assert_slot_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> |free_vec);
  assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_vec));
endmodule

// File: rtl/rd_capture_fifo.sv
module rd_capture_fifo
  import rcf_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 4,
  parameter int NUM_TIMERS = 4,
  parameter int CFGW       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issue,
  input  logic [CFGW-1:0] cfg_cl,
  input  logic [CFGW-1:0] cfg_ralat,
  input  logic            cfg_lp,
  input  logic            dqs_clk,
  input  logic            dqs_we,
  input  logic [DW-1:0]   dqs_data,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            rd_err
);
  localparam int TW = CFGW + 2;

  logic [TW-1:0]     delay;
  logic              fire, tmr_busy, empty, pop;
  logic [DW-1:0]     head;
  logic              act_q, act_d, err_q, err_d;
  logic [BEAT_W-1:0] beat_q, beat_d;

  assign delay = TW'(cfg_cl) + TW'(cfg_ralat) + (cfg_lp ? TW'(LP_EXTRA) : '0);

  lat_timers #(.NT(NUM_TIMERS), .TW(TW)) u_timers (
    .clk(clk), .rst_n(rst_n), .load(rd_issue), .load_val(delay),
    .fire(fire), .busy(tmr_busy)
  );

  capture_fifo #(.DW(DW), .AW(AW)) u_fifo (
    .wclk(dqs_clk), .rclk(clk), .rst_n(rst_n), .we(dqs_we), .wdata(dqs_data),
    .pop(pop), .empty(empty), .rdata(head)
  );

  always_comb begin
    act_d  = act_q;
    beat_d = beat_q;
    if (fire) begin
      act_d  = 1'b1;
      beat_d = '0;
    end else if (act_q) begin
      if (beat_q == BEAT_W'(BURST_LEN - 1)) act_d = 1'b0;
      else                                  beat_d = beat_q + 1'b1;
    end
    err_d = err_q | (act_q & empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      beat_q <= beat_d;
      err_q  <= err_d;
    end
  end

  assign pop      = act_q & ~empty;
  assign rd_valid = act_q;
  assign rd_data  = empty ? '1 : head;
  assign rd_err   = err_q;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(rd_err));
  assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> ($past(beat_q) == BEAT_W'(BURST_LEN - 1)));
  assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_busy || act_q) |-> $stable({cfg_cl, cfg_ralat, cfg_lp}));
endmodule

// File: tb/rd_capture_fifo_tb.sv
module rd_capture_fifo_tb;
  logic        clk = 1'b0, dqs_clk = 1'b0, rst_n = 1'b0;
  logic        rd_issue = 1'b0, cfg_lp = 1'b0, dqs_we = 1'b0;
  logic [3:0]  cfg_cl = 4'd4, cfg_ralat = 4'd1;
  logic [15:0] dqs_data = '0, rd_data;
  logic        rd_valid, rd_err;
  int          n_tests = 0, n_fail = 0;
  bit          exp_err = 1'b0;

  rd_capture_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .cfg_cl(cfg_cl),
    .cfg_ralat(cfg_ralat), .cfg_lp(cfg_lp), .dqs_clk(dqs_clk), .dqs_we(dqs_we),
    .dqs_data(dqs_data), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
  );

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #5 dqs_clk = ~dqs_clk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_read(input int cl, input int ral, input bit lp, input int nissue,
                          input int nwords, input logic [15:0] base);
    int d;
    string rq;
    d  = cl + ral + (lp ? 2 : 0);
    rq = lp ? "R4" : "R3";
    @(negedge clk);
    cfg_cl = 4'(cl); cfg_ralat = 4'(ral); cfg_lp = lp;
    fork
      begin
        rd_issue = 1'b1;
        @(negedge clk);
        rd_issue = 1'b0;
        if (nissue == 2) begin
          repeat (7) @(negedge clk);
          rd_issue = 1'b1;
          @(negedge clk);
          rd_issue = 1'b0;
        end
      end
      begin
        for (int i = 0; i < nwords; i++) begin
          @(negedge dqs_clk);
          dqs_we = 1'b1;
          dqs_data = base + 16'(i);
        end
        @(negedge dqs_clk);
        dqs_we = 1'b0;
      end
      begin
        @(posedge clk);
        repeat (d - 1) @(posedge clk);
        @(negedge clk);
        check(rd_valid == 1'b0, {rq, " not early"}, 32'(rd_valid), 0);
        for (int b = 0; b < 8 * nissue; b++) begin
          logic [15:0] e;
          e = (b < nwords) ? base + 16'(b) : 16'hFFFF;
          @(posedge clk);
          @(negedge clk);
          check(rd_valid == 1'b1, {rq, " R5 R6 valid beat"}, 32'(rd_valid), 1);
          check(rd_data == e, (b < nwords) ? "R2 data order" : "R7 underrun ones",
                32'(rd_data), 32'(e));
        end
        @(posedge clk);
        @(negedge clk);
        check(rd_valid == 1'b0, "R5 burst end", 32'(rd_valid), 0);
        if (nwords < 8 * nissue) exp_err = 1'b1;
        check(rd_err == exp_err, "R7 R8 error flag", 32'(rd_err), 32'(exp_err));
      end
    join
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0, "R1 reset valid", 32'(rd_valid), 0);
    check(rd_err == 1'b0, "R1 R8 reset error", 32'(rd_err), 0);
    rst_n = 1'b1;
    exp_err = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    n = 0;
    do_reset();
    for (int cl = 4; cl <= 6; cl++)
      for (int ral = 1; ral <= 3; ral++)
        for (int lp = 0; lp <= 1; lp++) begin
          run_read(cl, ral, 1'(lp), 1, 8, 16'h1000 + 16'(n * 16));
          n++;
        end
    run_read(6, 0, 0, 1, 8, 16'h2200);
    run_read(5, 2, 0, 1, 0, 16'h0000);
    run_read(5, 2, 0, 1, 3, 16'h3300);
    run_read(4, 1, 1, 1, 8, 16'h3400);
    run_read(5, 1, 0, 2, 16, 16'h4000);
    do_reset();
    run_read(6, 0, 1, 2, 16, 16'h5000);
    run_read(4, 3, 0, 1, 8, 16'h6000);
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule